// File: doc/BRIEF.md
# Segmented TLB Address Translator

This block turns a 32-bit virtual address into a physical address for an in-order core. It holds a fully associative table of entries. Each entry carries a virtual page number, an address-space identifier, a shared flag, a page-size code, a physical page number, a two-bit protection field, a dirty flag and a valid flag. Every request carries the access kind and the access size. One cycle after the request, the block returns the physical address together with a result code.

Before any table lookup, three checks run in order. A misaligned access is refused. Fixed privileged regions, chosen by the top three address bits, pass through untranslated. The on-chip RAM window also passes through, and so does every address while the global enable is low. The table is loaded one entry per cycle through a write port. A flush input invalidates the whole table in a single cycle.

Control is a two-state machine. The state ST_IDLE means that no response is being presented. The state ST_RESP means that a registered result is on the outputs. There are four transitions:
- ST_IDLE to ST_RESP (go_resp) on a request.
- ST_RESP to ST_RESP (stay_resp) on a back-to-back request.
- ST_RESP to ST_IDLE (go_idle) when no request follows.
- ST_IDLE to ST_IDLE (stay_idle) when there is no request.

Top module: `seg_tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every table entry is invalid, so the first translated lookup returns the miss code.
- R2: A request sampled at a clock edge is answered by `rsp_valid`=1 and its result during the following cycle. `rsp_valid` is 0 in any cycle that follows an edge with no request.
- R3: The size code `req_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. If `req_va` is not a multiple of min(size, 4), the result code is 5 (bad address) and `rsp_pa` is 0. This check has the highest priority.
- R4: While `xlate_en` is 0, every aligned access returns code 0 with `rsp_pa` equal to `req_va`.
- R5: When `req_va[31:29]` is 4, 5 or 7, or when `req_va[31:26]` is 6'b011111 (the on-chip RAM window), an aligned access returns code 0 with `rsp_pa` equal to `req_va`. Region values 0 to 3 and 6 are translated.
- R6: The page-size code selects the compared bits of `req_va`. Code 0 (1 KB) compares [31:10], code 1 (4 KB) compares [31:12], code 2 (64 KB) compares [31:16] and code 3 (1 MB) compares [31:20]. On a hit, the bits of `rsp_pa` above the page boundary come from the entry's page number and the bits below it come from `req_va`.
- R7: An entry matches only if it is valid and its ASID equals `req_asid`, unless its shared flag is set, in which case the ASID is not compared.
- R8: When no entry matches, the code is 1 (miss). When two or more entries match, the code is 2 (multi-hit). On any nonzero code, `rsp_pa` is 0.
- R9: The access type `req_type` is 0 for instruction fetch, 1 for data write and 2 for data read. Protection bit 1 grants user access and bit 0 grants write access. A user access (`req_user`=1) to an entry without bit 1 returns code 3. So does a write to an entry without bit 0. Multi-hit takes precedence over code 3.
- R10: A write that passes protection but hits an entry whose dirty flag is 0 returns code 4 (first write). Reads and fetches of that entry return code 0.
- R11: A flush invalidates all entries at one edge. A write presented in the same cycle as a flush still leaves its entry loaded and valid.
- R12: A lookup presented in the same cycle as a table write or flush is judged against the table as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Global translation enable |
| flush | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_valid | input | 1 | Valid flag for the loaded entry |
| wr_vpn | input | 22 | Virtual page number, VA[31:10] |
| wr_asid | input | 8 | Address-space identifier |
| wr_psize | input | 2 | Page-size code |
| wr_shared | input | 1 | Ignore ASID when set |
| wr_ppn | input | 22 | Physical page number, PA[31:10] |
| wr_prot | input | 2 | Protection: bit1 user, bit0 write |
| wr_dirty | input | 1 | Dirty flag |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_type | input | 2 | Access type code |
| req_size | input | 2 | Access size code |
| req_asid | input | 8 | Current ASID |
| req_user | input | 1 | User-mode access |
| rsp_valid | output | 1 | Result strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_err | output | 3 | Result code |

## Verification
Two things can fall on the same edge: a lookup, and a change to the table by a write or a flush. The bench presents a request in the very cycle that loads a matching entry, and again in the cycle that flushes a live entry. The response must reflect the old table, giving a miss and a hit respectively. A follow-up lookup must then see the new table. A flush and a write are also issued together, and the written entry must survive while every other entry is gone.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 22;
    localparam int ASID_W = 8;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_READ  = 2'd2;

    typedef enum logic [2:0] {
        XERR_NONE    = 3'd0,
        XERR_MISS    = 3'd1,
        XERR_MULTI   = 3'd2,
        XERR_PROT    = 3'd3,
        XERR_FIRSTWR = 3'd4,
        XERR_BADADDR = 3'd5
    } xerr_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [1:0]        psize;
        logic              shared;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_entry_t;

    // Compare mask over VA[31:10] for a page-size code.
    function automatic logic [VPN_W-1:0] page_mask(input logic [1:0] psize);
        logic [VPN_W-1:0] m;
        unique case (psize)
            2'd0: m = {VPN_W{1'b1}};
            2'd1: m = {{(VPN_W-2){1'b1}}, 2'b0};
            2'd2: m = {{(VPN_W-6){1'b1}}, 6'b0};
            default: m = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlbx_table.sv
module tlbx_table
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_entry,
    output tlb_entry_t [NUM_ENTRIES-1:0] tbl_o
);
    tlb_entry_t           ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_vec;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_entry;
            end else if (flush) begin
                ent_q[i].valid <= 1'b0;
            end
        end
        assign tbl_o[i]     = ent_q[i];
        assign valid_vec[i] = ent_q[i].valid;
    end

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !wr_en |=> (valid_vec == '0));

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_o[$past(wr_idx)] == $past(wr_entry)));

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
(
    input  tlb_entry_t        ent_i,
    input  logic [VPN_W-1:0]  va_vpn_i,
    input  logic [ASID_W-1:0] asid_i,
    output logic              hit_o,
    output logic [PPN_W-1:0]  page_o
);
    logic [VPN_W-1:0] mask;
    logic             asid_ok;

    always_comb begin
        mask    = page_mask(ent_i.psize);
        asid_ok = ent_i.shared || (ent_i.asid == asid_i);
        hit_o   = ent_i.valid && asid_ok && (((va_vpn_i ^ ent_i.vpn) & mask) == '0);
        page_o  = (ent_i.ppn & mask) | (va_vpn_i & ~mask);
    end
endmodule

// File: rtl/seg_tlb_xlate.sv
module seg_tlb_xlate
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [21:0]       wr_vpn,
    input  logic [7:0]        wr_asid,
    input  logic [1:0]        wr_psize,
    input  logic              wr_shared,
    input  logic [21:0]       wr_ppn,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic [1:0]        req_type,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_asid,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [31:0]       rsp_pa,
    output logic [2:0]        rsp_err
);
    typedef enum logic {ST_IDLE, ST_RESP} state_t;

    tlb_entry_t                   wr_entry;
    tlb_entry_t [NUM_ENTRIES-1:0] tbl;
    logic [NUM_ENTRIES-1:0]       hit_vec;
    logic [PPN_W-1:0]             page_arr [NUM_ENTRIES];

    state_t      state_q, state_d;
    xerr_t       err_d, err_q;
    logic [31:0] pa_d, pa_q;

    logic [2:0]       amask;
    logic             misaligned, bypass, is_write;
    logic [PPN_W-1:0] sel_page;
    logic [1:0]       sel_prot;
    logic             sel_dirty;
    logic [$clog2(NUM_ENTRIES+1)-1:0] hit_cnt;

    assign wr_entry = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid, psize: wr_psize,
                        shared: wr_shared, ppn: wr_ppn, prot: wr_prot, dirty: wr_dirty};

    tlbx_table #(.NUM_ENTRIES(NUM_ENTRIES)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .tbl_o    (tbl)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        tlbx_match match_i (
            .ent_i    (tbl[i]),
            .va_vpn_i (req_va[31:10]),
            .asid_i   (req_asid),
            .hit_o    (hit_vec[i]),
            .page_o   (page_arr[i])
        );
    end

    // Hit reduction: count and OR-select the hitting entry's fields.
    always_comb begin
        hit_cnt   = '0;
        sel_page  = '0;
        sel_prot  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            hit_cnt = hit_cnt + {{($bits(hit_cnt)-1){1'b0}}, hit_vec[i]};
            if (hit_vec[i]) begin
                sel_page  = sel_page | page_arr[i];
                sel_prot  = sel_prot | tbl[i].prot;
                sel_dirty = sel_dirty | tbl[i].dirty;
            end
        end
    end

    // Pre-checks and result priority.
    always_comb begin
        unique case (req_size)
            2'd0:    amask = 3'b000;
            2'd1:    amask = 3'b001;
            default: amask = 3'b011;
        endcase
        misaligned = |(req_va[2:0] & amask);
        bypass     = !xlate_en || (req_va[31:29] == 3'd4) || (req_va[31:29] == 3'd5) ||
                     (req_va[31:29] == 3'd7) || (req_va[31:26] == 6'b011111);
        is_write   = (req_type == ACC_WRITE);

        err_d = XERR_NONE;
        pa_d  = '0;
        if (misaligned) begin
            err_d = XERR_BADADDR;
        end else if (bypass) begin
            pa_d = req_va;
        end else if (hit_cnt > 1) begin
            err_d = XERR_MULTI;
        end else if (hit_cnt == 0) begin
            err_d = XERR_MISS;
        end else if ((req_user && !sel_prot[1]) || (is_write && !sel_prot[0])) begin
            err_d = XERR_PROT;
        end else if (is_write && !sel_dirty) begin
            err_d = XERR_FIRSTWR;
        end else begin
            pa_d = {sel_page, req_va[9:0]};
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= XERR_NONE;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                err_q <= err_d;
                pa_q  <= pa_d;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        rsp_valid = 1'b0;
        rsp_pa    = '0;
        rsp_err   = XERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                state_d = req_valid ? ST_RESP : ST_IDLE;
            end
            ST_RESP: begin
                state_d   = req_valid ? ST_RESP : ST_IDLE;
                rsp_valid = 1'b1;
                rsp_pa    = pa_q;
                rsp_err   = err_q;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_strobe_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_misalign_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && misaligned |=> (rsp_err == XERR_BADADDR));

    assert_disabled_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlate_en && !misaligned |=> (rsp_err == XERR_NONE) && (rsp_pa == $past(req_va)));

    assert_region_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !misaligned && (req_va[31:29] == 3'd4 || req_va[31:29] == 3'd5 ||
        req_va[31:29] == 3'd7 || req_va[31:26] == 6'b011111)
        |=> (rsp_err == XERR_NONE) && (rsp_pa == $past(req_va)));

    assert_multi_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !misaligned && !bypass && ($countones(hit_vec) > 1) |=> (rsp_err == XERR_MULTI));

    assert_err_zero_pa_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_err != XERR_NONE) |-> (rsp_pa == '0));
endmodule

// File: tb/seg_tlb_xlate_tb_top.sv
module seg_tlb_xlate_tb_top;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0, flush = 1'b0, wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0, wr_shared = 1'b0, wr_dirty = 1'b0;
    logic [21:0] wr_vpn = '0, wr_ppn = '0;
    logic [7:0]  wr_asid = '0, req_asid = '0;
    logic [1:0]  wr_psize = '0, wr_prot = '0, req_type = '0, req_size = '0;
    logic        req_valid = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_tlb_xlate dut_i (.*);

    // Bench model of the table.
    bit          m_valid [N];
    logic [21:0] m_vpn [N], m_ppn [N];
    logic [7:0]  m_asid [N];
    logic [1:0]  m_psize [N], m_prot [N];
    bit          m_shared [N], m_dirty [N];

    function automatic logic [34:0] model(input logic [31:0] va, input logic [1:0] typ,
                                          input logic [1:0] sz, input logic [7:0] asid,
                                          input logic usr);
        int bytes, cnt, low;
        logic [21:0] msk, page;
        bit wr, p_user, p_wr, dirty;
        bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if ((va % bytes) != 0) return {3'd5, 32'd0};
        if (!xlate_en || va[31:29] == 3'd4 || va[31:29] == 3'd5 || va[31:29] == 3'd7 ||
            (va >= 32'h7C00_0000 && va <= 32'h7FFF_FFFF))
            return {3'd0, va};
        cnt = 0; page = '0; p_user = 0; p_wr = 0; dirty = 0;
        for (int i = 0; i < N; i++) begin
            low = (m_psize[i] == 0) ? 0 : (m_psize[i] == 1) ? 2 : (m_psize[i] == 2) ? 6 : 10;
            msk = 22'h3FFFFF << low;
            if (m_valid[i] && (m_shared[i] || m_asid[i] == asid) &&
                ((va[31:10] & msk) == (m_vpn[i] & msk))) begin
                cnt++;
                page = (m_ppn[i] & msk) | (va[31:10] & ~msk);
                p_user = m_prot[i][1]; p_wr = m_prot[i][0]; dirty = m_dirty[i];
            end
        end
        wr = (typ == 2'd1);
        if (cnt > 1) return {3'd2, 32'd0};
        if (cnt == 0) return {3'd1, 32'd0};
        if ((usr && !p_user) || (wr && !p_wr)) return {3'd3, 32'd0};
        if (wr && !dirty) return {3'd4, 32'd0};
        return {3'd0, page, va[9:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_wr(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                          input logic [1:0] ps, input bit sh, input logic [21:0] ppn,
                          input logic [1:0] prot, input bit dirty, input bit vld);
        wr_idx = idx[5:0]; wr_vpn = vpn; wr_asid = asid; wr_psize = ps; wr_shared = sh;
        wr_ppn = ppn; wr_prot = prot; wr_dirty = dirty; wr_valid = vld;
    endtask

    task automatic set_req(input logic [31:0] va, input logic [1:0] typ, input logic [1:0] sz,
                           input logic [7:0] asid, input bit usr);
        req_va = va; req_type = typ; req_size = sz; req_asid = asid; req_user = usr;
    endtask

    // One cycle: optional flush, write and lookup together; starts and ends at negedge.
    task automatic step(input bit do_fl, input bit do_wr, input bit do_rq, input string tag);
        logic [34:0] exp;
        exp = model(req_va, req_type, req_size, req_asid, req_user);
        flush = do_fl; wr_en = do_wr; req_valid = do_rq;
        @(posedge clk);
        if (do_fl) for (int i = 0; i < N; i++) m_valid[i] = 0;
        if (do_wr) begin
            m_valid[wr_idx] = wr_valid; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
            m_psize[wr_idx] = wr_psize; m_shared[wr_idx] = wr_shared; m_ppn[wr_idx] = wr_ppn;
            m_prot[wr_idx] = wr_prot; m_dirty[wr_idx] = wr_dirty;
        end
        @(negedge clk);
        flush = 0; wr_en = 0; req_valid = 0;
        if (do_rq) begin
            chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
            chk({tag, " code/pa"}, 64'({rsp_err, rsp_pa}), 64'(exp));
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] typ, input logic [1:0] sz,
                        input logic [7:0] asid, input bit usr, input string tag);
        set_req(va, typ, sz, asid, usr);
        step(0, 0, 1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
            m_psize[i] = '0; m_prot[i] = '0; m_shared[i] = 0; m_dirty[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        xlate_en = 1'b1;
        look(32'h0000_1000, 2'd2, 2'd2, 8'd0, 0, "R1 empty table miss");
        chk("R1 miss code", 64'(rsp_err), 64'd1);
        // R2: strobe drops with no request.
        @(negedge clk);
        chk("R2 idle strobe", 64'(rsp_valid), 64'd0);
        look(32'h8000_0000, 2'd2, 2'd0, 8'd0, 0, "R2 first of pair");
        look(32'h8000_0004, 2'd2, 2'd0, 8'd0, 0, "R2 second of pair");
        @(negedge clk);
        chk("R2 strobe after pair", 64'(rsp_valid), 64'd0);

        // R3: alignment sweep, bypass and translated regions.
        for (int s = 0; s < 4; s++)
            for (int lo = 0; lo < 8; lo++) begin
                look(32'hA000_0010 | lo, 2'd2, s[1:0], 8'd0, 0, "R3 align bypass");
                look(32'h0000_2000 | lo, 2'd1, s[1:0], 8'd0, 0, "R3 align translated");
            end

        // R4: disabled translation.
        xlate_en = 1'b0;
        for (int r = 0; r < 8; r++)
            look({r[2:0], 29'h0123_4568}, r[1:0] == 2'd3 ? 2'd2 : r[1:0], 2'd2, 8'd1, r[0], "R4 disabled pass");
        xlate_en = 1'b1;

        // R5: region decode and on-chip window on an empty table.
        for (int r = 0; r < 8; r++)
            look({r[2:0], 29'h0ABC_DE0}, 2'd2, 2'd2, 8'd0, 0, "R5 region");
        look(32'h7C00_1234, 2'd1, 2'd2, 8'd0, 1, "R5 window low");
        look(32'h7FFF_FFF0, 2'd2, 2'd3, 8'd0, 0, "R5 window high");
        look(32'h7BFF_FFF0, 2'd2, 2'd2, 8'd0, 0, "R5 below window");

        // R6: page sizes, bit-flip sweep around one entry.
        for (int ps = 0; ps < 4; ps++) begin
            set_wr(5, 22'h048D15, 8'd7, ps[1:0], 0, 22'h2AF3C9, 2'd3, 1, 1);
            step(1, 1, 0, "R6 load");
            look(32'h1234_5678, 2'd2, 2'd2, 8'd7, 0, "R6 base hit");
            for (int k = 2; k < 32; k++)
                look(32'h1234_5678 ^ (32'd1 << k), 2'd2, 2'd2, 8'd7, 0, "R6 flip");
        end

        // R7: ASID and shared flag.
        set_wr(9, 22'h000040, 8'd3, 2'd1, 0, 22'h100000, 2'd3, 1, 1);
        step(1, 1, 0, "R7 load");
        look(32'h0001_0044, 2'd2, 2'd2, 8'd3, 0, "R7 asid equal");
        look(32'h0001_0044, 2'd2, 2'd2, 8'd4, 0, "R7 asid differ");
        set_wr(9, 22'h000040, 8'd3, 2'd1, 1, 22'h100000, 2'd3, 1, 1);
        step(0, 1, 0, "R7 shared load");
        look(32'h0001_0044, 2'd2, 2'd2, 8'd4, 0, "R7 shared hit");

        // R8: multi-hit; R9 priority over protection.
        set_wr(20, 22'h000400, 8'd1, 2'd3, 0, 22'h000C00, 2'd0, 1, 1);
        step(0, 1, 0, "R8 load big");
        set_wr(21, 22'h000404, 8'd1, 2'd1, 0, 22'h000800, 2'd3, 1, 1);
        step(0, 1, 0, "R8 load small");
        look(32'h0010_1008, 2'd2, 2'd2, 8'd1, 0, "R8 multi");
        look(32'h0010_1008, 2'd1, 2'd2, 8'd1, 1, "R9 multi over prot");
        look(32'h0018_0000, 2'd2, 2'd2, 8'd1, 0, "R8 single big");

        // R9: protection sweep, dirty set.
        for (int p = 0; p < 4; p++) begin
            set_wr(30, 22'h0C0000, 8'd2, 2'd2, 0, 22'h155540, p[1:0], 1, 1);
            step(1, 1, 0, "R9 load");
            for (int t = 0; t < 3; t++)
                for (int u = 0; u < 2; u++)
                    look(32'h3000_ABCC, t[1:0], 2'd2, 8'd2, u[0], "R9 prot");
        end

        // R10: first write.
        set_wr(31, 22'h0C0000, 8'd2, 2'd2, 0, 22'h155540, 2'd3, 0, 1);
        step(1, 1, 0, "R10 load clean");
        look(32'h3000_0100, 2'd1, 2'd2, 8'd2, 0, "R10 first write");
        look(32'h3000_0100, 2'd2, 2'd2, 8'd2, 0, "R10 read clean");
        look(32'h3000_0100, 2'd0, 2'd1, 8'd2, 1, "R10 fetch clean");
        set_wr(31, 22'h0C0000, 8'd2, 2'd2, 0, 22'h155540, 2'd2, 0, 1);
        step(0, 1, 0, "R10 load ro");
        look(32'h3000_0100, 2'd1, 2'd2, 8'd2, 0, "R10 prot before first write");

        // R11: flush with concurrent write.
        set_wr(40, 22'h001000, 8'd0, 2'd0, 1, 22'h000123, 2'd3, 1, 1);
        step(0, 1, 0, "R11 preload");
        set_wr(41, 22'h002000, 8'd0, 2'd0, 1, 22'h000456, 2'd3, 1, 1);
        step(1, 1, 0, "R11 flush+write");
        look(32'h0080_0010, 2'd2, 2'd2, 8'd0, 0, "R11 written survives");
        look(32'h0040_0010, 2'd2, 2'd2, 8'd0, 0, "R11 others flushed");
        step(1, 0, 0, "R11 flush");
        look(32'h0080_0010, 2'd2, 2'd2, 8'd0, 0, "R11 flushed miss");

        // R12: lookup same cycle as write, then as flush.
        set_wr(50, 22'h003000, 8'd0, 2'd0, 1, 22'h000789, 2'd3, 1, 1);
        set_req(32'h00C0_0020, 2'd2, 2'd2, 8'd0, 0);
        step(0, 1, 1, "R12 lookup with write");
        chk("R12 old table miss", 64'(rsp_err), 64'd1);
        look(32'h00C0_0020, 2'd2, 2'd2, 8'd0, 0, "R12 after write");
        set_req(32'h00C0_0020, 2'd2, 2'd2, 8'd0, 0);
        step(1, 0, 1, "R12 lookup with flush");
        chk("R12 old table hit", 64'(rsp_err), 64'd0);
        look(32'h00C0_0020, 2'd2, 2'd2, 8'd0, 0, "R12 after flush");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule